// File: doc/BRIEF.md
# Cache-Line Store Merge Buffer

This block stages committed stores between the head of a store queue and the write port of an L1 data cache. Each staging entry covers one 64-byte line and holds the line number, the line data and a per-byte valid mask. When a committed store targets a line that already has an open entry, its bytes are merged into that entry. Such a store does not cause its own cache write. Each entry reaches the cache later as one line write with byte enables. Merging happens only here, after stores have left the store queue. Entries inside the queue are never combined.

Up to two committed stores arrive per cycle on two ordered lanes. Lane 0 is the older store. Both stores can be absorbed in the same cycle. A store that runs past the end of its line is cut into two line-local pieces, and each piece lands in its own entry. Entries leave oldest first. An entry leaves when a store needs room that is not there, or when a flush is requested, for example at a fence. The cache write port can be held busy by a refill. While it is busy, stores that merge into open entries keep retiring.

Top module: `store_merge_buf`

## Requirements
- R1: After reset no entry is occupied: `stageEmpty` is 1 and `wrVld` is 0.
- R2: Stores to the same line are merged into one entry. Later stores overwrite bytes written by earlier ones. The entry leaves as a single write whose mask bit b is set exactly for the bytes written. Data byte b is on `wrData[8b+7:8b]`. Store data is little-endian: byte 0 of `stData` goes to the lowest address. Size code k means 2^k bytes.
- R3: A store whose bytes pass the end of its line is split. Its low part goes to the line of `stAddr`, and its remaining bytes go to the next line starting at offset 0. The two parts occupy two entries and leave as two writes, lower line first.
- R4: Lane 1 is taken only in a cycle where lane 0 is also taken. Both lanes can be taken in one cycle, either merging into a shared line or allocating two entries. Where they overlap, lane 1's bytes win.
- R5: A store is not taken if it needs more new entries than are free. In that cycle, if the port is not busy, the oldest entry is written out. The store is taken in a later cycle.
- R6: `wrVld` is never 1 while `portBusy` is 1. A store that merges into an open entry is still taken while the port is busy.
- R7: While `flushReq` is 1, no store is taken. On each cycle with the port free, the oldest entry is written out, until `stageEmpty` rises.
- R8: An entry is never written out without need. With no flush and no store lacking room, `wrVld` stays 0 and the entries keep their bytes.
- R9: `wrLine` equals address bits [ADDR_W-1:6] of the bytes in the entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| stVld | input | 2 | Committed store present, per lane (lane 0 older) |
| stAddr | input | 2x40 | Byte address of each store |
| stData | input | 2x64 | Store data, little-endian |
| stSize | input | 2x2 | Size code k, store is 2^k bytes |
| stTake | output | 2 | Store taken this cycle, per lane |
| flushReq | input | 1 | Drain all entries and hold off stores |
| portBusy | input | 1 | Cache write port unavailable this cycle |
| wrVld | output | 1 | Line write issued this cycle |
| wrLine | output | 34 | Line number of the write |
| wrMask | output | 64 | Byte enables of the write |
| wrData | output | 512 | Line data of the write |
| stageEmpty | output | 1 | No entry occupied |

## Verification
The merge path is tried with three kinds of traffic: repeated single-lane stores to one line with overlapping bytes, a store that straddles a line end, and same-cycle lane pairs that either share a line or need two fresh entries. These separate byte-order and overwrite errors from wrong entry choice and from lost lane-1 stores. Pressure cases fill both entries and then offer a fresh line with the port free, with the port busy, and with lane 1 hitting an open line behind a blocked lane 0. These separate eviction order from illegal writes during refills and from out-of-order lane acceptance. Flushes with the port busy and then free confirm that stores are held off and that entries leave oldest first.

// File: rtl/smb_pkg.sv
package smb_pkg;
  localparam int LINE_BYTES  = 64;
  localparam int ENTRIES     = 2;   // at least 2, so a split store can always be placed
  localparam int LANES       = 2;
  localparam int STORE_BYTES = 8;
  localparam int ADDR_W      = 40;

  localparam int OFF_W      = $clog2(LINE_BYTES);
  localparam int LINE_W     = ADDR_W - OFF_W;
  localparam int LINE_BITS  = LINE_BYTES * 8;
  localparam int STORE_BITS = STORE_BYTES * 8;
  localparam int SIZE_W     = $clog2($clog2(STORE_BYTES) + 1);
  localparam int SLOT_W     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int CNT_W      = $clog2(ENTRIES + 1);
  localparam int PIECES     = 2 * LANES;   // each lane may yield a low and a high piece

  // control -> datapath strobes
  typedef struct packed {
    logic [PIECES-1:0]             go;     // piece is written this cycle
    logic [PIECES-1:0]             fresh;  // piece opens its entry
    logic [PIECES-1:0][SLOT_W-1:0] slot;   // target entry of each piece
    logic                          drain;  // head entry leaves this cycle
    logic [SLOT_W-1:0]             head;   // oldest entry
  } mergeStrobe_t;
endpackage

// File: rtl/smb_split.sv
module smb_split
  import smb_pkg::*;
(
  input  logic [ADDR_W-1:0]     addr,
  input  logic [STORE_BITS-1:0] data,
  input  logic [SIZE_W-1:0]     size,
  output logic [LINE_W-1:0]     loLine,
  output logic [LINE_W-1:0]     hiLine,
  output logic                  spans,
  output logic [LINE_BYTES-1:0] loMask,
  output logic [LINE_BYTES-1:0] hiMask,
  output logic [LINE_BITS-1:0]  loData,
  output logic [LINE_BITS-1:0]  hiData
);
  logic [OFF_W-1:0]          off;
  logic [OFF_W+1:0]          endPos;
  logic [OFF_W+1:0]          nBytes;
  logic [STORE_BYTES-1:0]    baseMask;
  logic [2*LINE_BYTES-1:0]   wideMask;
  logic [2*LINE_BITS-1:0]    wideData;

  always_comb begin
    off    = addr[OFF_W-1:0];
    nBytes = (OFF_W+2)'(1) << size;
    endPos = {2'b00, off} + nBytes;
    spans  = endPos > (OFF_W+2)'(LINE_BYTES);
    for (int b = 0; b < STORE_BYTES; b++) begin
      baseMask[b] = (OFF_W+2)'(b) < nBytes;
    end
    wideMask = (2*LINE_BYTES)'(baseMask) << off;
    wideData = (2*LINE_BITS)'(data) << {off, 3'b000};
  end

  assign loLine = addr[ADDR_W-1:OFF_W];
  assign hiLine = loLine + LINE_W'(1);
  assign loMask = wideMask[LINE_BYTES-1:0];
  assign hiMask = wideMask[2*LINE_BYTES-1:LINE_BYTES];
  assign loData = wideData[LINE_BITS-1:0];
  assign hiData = wideData[2*LINE_BITS-1:LINE_BITS];
endmodule

// File: rtl/smb_ctrl.sv
module smb_ctrl
  import smb_pkg::*;
(
  input  logic                             clk,
  input  logic                             rstN,
  input  logic [LANES-1:0]                 laneVld,
  input  logic [PIECES-1:0]                piecePresent,
  input  logic [PIECES-1:0][LINE_W-1:0]    pieceLine,
  input  logic                             flushReq,
  input  logic                             portBusy,
  output logic [LANES-1:0]                 laneTake,
  output mergeStrobe_t                     strobe,
  output logic [LINE_W-1:0]                drainLine,
  output logic                             isEmpty
);
  logic [ENTRIES-1:0]             entVld, entVldNext;
  logic [ENTRIES-1:0][LINE_W-1:0] entLine, entLineNext;
  logic [SLOT_W-1:0]              headPtr, headNext, tailPtr;
  logic [CNT_W-1:0]               cnt, cntNext, freeCnt, need0;
  logic                           wantDrain, drainFire;

  function automatic logic [SLOT_W-1:0] slotWrap(input int v);
    return (v >= ENTRIES) ? SLOT_W'(v - ENTRIES) : SLOT_W'(v);
  endfunction

  assign tailPtr = slotWrap(int'(headPtr) + int'(cnt));
  assign freeCnt = CNT_W'(ENTRIES) - cnt;

  // new entries the older lane needs, judged against the open entries
  always_comb begin
    logic hit;
    need0 = '0;
    for (int h = 0; h < 2; h++) begin
      hit = 1'b0;
      for (int e = 0; e < ENTRIES; e++) begin
        if (entVld[e] && entLine[e] == pieceLine[h]) hit = 1'b1;
      end
      if (piecePresent[h] && !hit) need0 = need0 + CNT_W'(1);
    end
  end

  assign wantDrain = (cnt != '0) && (flushReq || (laneVld[0] && need0 > freeCnt));
  assign drainFire = wantDrain && !portBusy;

  // in-order placement of lane pieces; a lane is all or nothing
  always_comb begin
    logic [ENTRIES-1:0]             tVld;
    logic [ENTRIES-1:0][LINE_W-1:0] tLine;
    logic [PIECES-1:0][SLOT_W-1:0]  tSlot;
    logic [PIECES-1:0]              tFresh;
    int   allocs, tAllocs;
    logic chain, laneOk, found;

    entVldNext  = entVld;
    entLineNext = entLine;
    laneTake    = '0;
    strobe      = '0;
    tSlot       = '0;
    tFresh      = '0;
    tVld        = entVld;
    tLine       = entLine;
    allocs      = 0;
    tAllocs     = 0;
    found       = 1'b0;
    chain       = !wantDrain && !flushReq;

    for (int l = 0; l < LANES; l++) begin
      tVld    = entVldNext;
      tLine   = entLineNext;
      tAllocs = allocs;
      laneOk  = chain && laneVld[l];
      for (int h = 0; h < 2; h++) begin
        if (laneOk && piecePresent[l*2+h]) begin
          found = 1'b0;
          for (int e = 0; e < ENTRIES; e++) begin
            if (!found && tVld[e] && tLine[e] == pieceLine[l*2+h]) begin
              found        = 1'b1;
              tSlot[l*2+h] = SLOT_W'(e);
            end
          end
          if (!found) begin
            if (tAllocs < int'(freeCnt)) begin
              tSlot[l*2+h]        = slotWrap(int'(tailPtr) + tAllocs);
              tFresh[l*2+h]       = 1'b1;
              tVld[tSlot[l*2+h]]  = 1'b1;
              tLine[tSlot[l*2+h]] = pieceLine[l*2+h];
              tAllocs             = tAllocs + 1;
            end else begin
              laneOk = 1'b0;
            end
          end
        end
      end
      if (laneOk) begin
        entVldNext  = tVld;
        entLineNext = tLine;
        allocs      = tAllocs;
        laneTake[l] = 1'b1;
        for (int h = 0; h < 2; h++) begin
          strobe.go[l*2+h]    = piecePresent[l*2+h];
          strobe.fresh[l*2+h] = tFresh[l*2+h];
          strobe.slot[l*2+h]  = tSlot[l*2+h];
        end
      end else begin
        chain = 1'b0;
      end
    end

    strobe.drain = drainFire;
    strobe.head  = headPtr;
    if (drainFire) entVldNext[headPtr] = 1'b0;
    cntNext  = cnt + CNT_W'(allocs) - CNT_W'(drainFire);
    headNext = drainFire ? slotWrap(int'(headPtr) + 1) : headPtr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      entVld  <= '0;
      entLine <= '0;
      headPtr <= '0;
      cnt     <= '0;
    end else begin
      entVld  <= entVldNext;
      entLine <= entLineNext;
      headPtr <= headNext;
      cnt     <= cntNext;
    end
  end

  assign drainLine = entLine[headPtr];
  assign isEmpty   = (cnt == '0);
endmodule

// File: rtl/smb_data.sv
module smb_data
  import smb_pkg::*;
(
  input  logic                               clk,
  input  logic                               rstN,
  input  mergeStrobe_t                       strobe,
  input  logic [PIECES-1:0][LINE_BYTES-1:0]  pieceMask,
  input  logic [PIECES-1:0][LINE_BITS-1:0]   pieceData,
  output logic [LINE_BYTES-1:0]              outMask,
  output logic [LINE_BITS-1:0]               outData
);
  logic [ENTRIES-1:0][LINE_BYTES-1:0] entMask, nMask;
  logic [ENTRIES-1:0][LINE_BITS-1:0]  entData, nData;

  // pieces applied in age order so younger bytes overwrite older ones
  always_comb begin
    nMask = entMask;
    nData = entData;
    for (int e = 0; e < ENTRIES; e++) begin
      for (int p = 0; p < PIECES; p++) begin
        if (strobe.go[p] && strobe.slot[p] == SLOT_W'(e)) begin
          if (strobe.fresh[p]) nMask[e] = '0;
          for (int b = 0; b < LINE_BYTES; b++) begin
            if (pieceMask[p][b]) begin
              nMask[e][b]        = 1'b1;
              nData[e][b*8 +: 8] = pieceData[p][b*8 +: 8];
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) entMask <= '0;
    else       entMask <= nMask;
  end

  always_ff @(posedge clk) begin
    entData <= nData;
  end

  assign outMask = entMask[strobe.head];
  assign outData = entData[strobe.head];
endmodule

// File: rtl/store_merge_buf.sv
module store_merge_buf
  import smb_pkg::*;
(
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [LANES-1:0]                  stVld,
  input  logic [LANES-1:0][ADDR_W-1:0]      stAddr,
  input  logic [LANES-1:0][STORE_BITS-1:0]  stData,
  input  logic [LANES-1:0][SIZE_W-1:0]      stSize,
  output logic [LANES-1:0]                  stTake,
  input  logic                              flushReq,
  input  logic                              portBusy,
  output logic                              wrVld,
  output logic [LINE_W-1:0]                 wrLine,
  output logic [LINE_BYTES-1:0]             wrMask,
  output logic [LINE_BITS-1:0]              wrData,
  output logic                              stageEmpty
);
  logic [PIECES-1:0]                  piecePresent;
  logic [PIECES-1:0][LINE_W-1:0]      pieceLine;
  logic [PIECES-1:0][LINE_BYTES-1:0]  pieceMask;
  logic [PIECES-1:0][LINE_BITS-1:0]   pieceData;
  logic [LANES-1:0]                   laneSpans;
  mergeStrobe_t                       strobe;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    smb_split u_split (
      .addr   (stAddr[l]),
      .data   (stData[l]),
      .size   (stSize[l]),
      .loLine (pieceLine[2*l]),
      .hiLine (pieceLine[2*l+1]),
      .spans  (laneSpans[l]),
      .loMask (pieceMask[2*l]),
      .hiMask (pieceMask[2*l+1]),
      .loData (pieceData[2*l]),
      .hiData (pieceData[2*l+1])
    );
    assign piecePresent[2*l]   = stVld[l];
    assign piecePresent[2*l+1] = stVld[l] && laneSpans[l];
  end

  smb_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .laneVld      (stVld),
    .piecePresent (piecePresent),
    .pieceLine    (pieceLine),
    .flushReq     (flushReq),
    .portBusy     (portBusy),
    .laneTake     (stTake),
    .strobe       (strobe),
    .drainLine    (wrLine),
    .isEmpty      (stageEmpty)
  );

  smb_data u_data (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .pieceMask (pieceMask),
    .pieceData (pieceData),
    .outMask   (wrMask),
    .outData   (wrData)
  );

  assign wrVld = strobe.drain;
endmodule

// File: rtl/store_merge_buf_chk.sv
module store_merge_buf_chk
  import smb_pkg::*;
(
  input logic                  clk,
  input logic                  rstN,
  input logic [LANES-1:0]      stVld,
  input logic [LANES-1:0]      stTake,
  input logic                  flushReq,
  input logic                  portBusy,
  input logic                  wrVld,
  input logic [LINE_BYTES-1:0] wrMask,
  input logic                  stageEmpty
);
  // R1: a reset cycle leaves the buffer empty
  p_reset_empty_r1: assert property (@(posedge clk) !rstN |=> stageEmpty);

  // R2: every line write carries at least one enabled byte
  p_mask_nonzero_r2: assert property (@(posedge clk) disable iff (!rstN)
    wrVld |-> wrMask != '0);

  // R4: the younger lane never overtakes the older one
  p_lane_order_r4: assert property (@(posedge clk) disable iff (!rstN)
    stTake[1] |-> stTake[0]);

  // R4: nothing is taken that was not offered
  p_take_offered_r4: assert property (@(posedge clk) disable iff (!rstN)
    (stTake & ~stVld) == '0);

  // R6: no write while the port is held
  p_no_write_busy_r6: assert property (@(posedge clk) disable iff (!rstN)
    portBusy |-> !wrVld);

  // R7: flush holds off stores
  p_flush_blocks_r7: assert property (@(posedge clk) disable iff (!rstN)
    flushReq |-> stTake == '0);

  // R7: flush with a free port always makes progress
  p_flush_drains_r7: assert property (@(posedge clk) disable iff (!rstN)
    (flushReq && !stageEmpty && !portBusy) |-> wrVld);

  // R8: an empty buffer never writes
  p_empty_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    stageEmpty |-> !wrVld);
endmodule

bind store_merge_buf store_merge_buf_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .stVld      (stVld),
  .stTake     (stTake),
  .flushReq   (flushReq),
  .portBusy   (portBusy),
  .wrVld      (wrVld),
  .wrMask     (wrMask),
  .stageEmpty (stageEmpty)
);

// File: tb/store_merge_buf_bench.sv
`timescale 1ns/1ps
module store_merge_buf_bench;
  import smb_pkg::*;

  logic                              clk = 1'b0;
  logic                              rstN;
  logic [LANES-1:0]                  stVld;
  logic [LANES-1:0][ADDR_W-1:0]      stAddr;
  logic [LANES-1:0][STORE_BITS-1:0]  stData;
  logic [LANES-1:0][SIZE_W-1:0]      stSize;
  logic [LANES-1:0]                  stTake;
  logic                              flushReq;
  logic                              portBusy;
  logic                              wrVld;
  logic [LINE_W-1:0]                 wrLine;
  logic [LINE_BYTES-1:0]             wrMask;
  logic [LINE_BITS-1:0]              wrData;
  logic                              stageEmpty;

  store_merge_buf u_store_merge_buf (
    .clk(clk), .rstN(rstN), .stVld(stVld), .stAddr(stAddr), .stData(stData),
    .stSize(stSize), .stTake(stTake), .flushReq(flushReq), .portBusy(portBusy),
    .wrVld(wrVld), .wrLine(wrLine), .wrMask(wrMask), .wrData(wrData),
    .stageEmpty(stageEmpty)
  );

  always #4 clk = ~clk;   // 125 MHz

  int total = 0;
  int bad   = 0;

  // write log, filled away from the clock edge
  int                    logCnt = 0;
  logic [LINE_W-1:0]     logLine [16];
  logic [LINE_BYTES-1:0] logMask [16];
  logic [LINE_BITS-1:0]  logData [16];
  logic [LANES-1:0]      takeSeen;
  logic                  wrSeen;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    stVld    = '0;
    stAddr   = '0;
    stData   = '0;
    stSize   = '0;
  endtask

  task automatic setLane(input int l, input logic [LINE_W-1:0] line, input int off,
                         input logic [63:0] data, input int sz);
    stVld[l]  = 1'b1;
    stAddr[l] = {line, OFF_W'(off)};
    stData[l] = data;
    stSize[l] = SIZE_W'(sz);
  endtask

  // sample the cycle, then move to the next negedge
  task automatic tick();
    #1;
    takeSeen = stTake;
    wrSeen   = wrVld;
    if (wrVld && logCnt < 16) begin
      logLine[logCnt] = wrLine;
      logMask[logCnt] = wrMask;
      logData[logCnt] = wrData;
      logCnt++;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic flushAll();
    idle();
    flushReq = 1'b1;
    for (int n = 0; n < 8 && !stageEmpty; n++) tick();
    flushReq = 1'b0;
  endtask

  task automatic testReset();
    chk("R1 empty after reset", 64'(stageEmpty), 64'd1);
    #1;
    chk("R1 no write after reset", 64'(wrVld), 64'd0);
    @(negedge clk);
  endtask

  task automatic testSameLine();
    int base;
    base = logCnt;
    idle(); setLane(0, 34'h100, 0, 64'h8877665544332211, 3); tick();
    chk("R2 first store taken", 64'(takeSeen), 64'd1);
    idle(); setLane(0, 34'h100, 4, 64'hDDCCBBAA, 2); tick();
    chk("R2 overlapping store taken", 64'(takeSeen), 64'd1);
    idle(); setLane(0, 34'h100, 63, 64'hEE, 0); tick();
    idle(); tick(); tick();
    chk("R8 no write while merging", 64'(logCnt - base), 64'd0);
    flushAll();
    chk("R7 flush gives one write", 64'(logCnt - base), 64'd1);
    chk("R9 line of merged write", 64'(logLine[base]), 64'h100);
    chk("R2 union mask", logMask[base], 64'h80000000000000FF);
    chk("R2 later bytes win", logData[base][63:0], 64'hDDCCBBAA44332211);
    chk("R2 last byte", 64'(logData[base][511:504]), 64'hEE);
    chk("R7 empty after flush", 64'(stageEmpty), 64'd1);
  endtask

  task automatic testSplit();
    int base;
    base = logCnt;
    idle(); setLane(0, 34'h200, 60, 64'h0807060504030201, 3); tick();
    chk("R3 split store taken at once", 64'(takeSeen), 64'd1);
    flushAll();
    chk("R3 two writes", 64'(logCnt - base), 64'd2);
    chk("R3 low line first", 64'(logLine[base]), 64'h200);
    chk("R3 low mask", logMask[base], 64'hF000000000000000);
    chk("R3 low bytes", 64'(logData[base][511:480]), 64'h04030201);
    chk("R3 high line", 64'(logLine[base+1]), 64'h201);
    chk("R3 high mask", logMask[base+1], 64'h000000000000000F);
    chk("R3 high bytes", 64'(logData[base+1][31:0]), 64'h08070605);
  endtask

  task automatic testTwoLanes();
    int base;
    base = logCnt;
    idle();
    setLane(0, 34'h300, 8, 64'h44332211, 2);
    setLane(1, 34'h300, 10, 64'hBBAA, 1);
    tick();
    chk("R4 both lanes same line", 64'(takeSeen), 64'd3);
    flushAll();
    chk("R4 shared line one write", 64'(logCnt - base), 64'd1);
    chk("R4 shared mask", logMask[base], 64'h0000000000000F00);
    chk("R4 lane1 wins overlap", 64'(logData[base][95:64]), 64'hBBAA2211);

    base = logCnt;
    idle();
    setLane(0, 34'h400, 0, 64'h5A, 0);
    setLane(1, 34'h500, 1, 64'hA5, 0);
    tick();
    chk("R4 both lanes two new lines", 64'(takeSeen), 64'd3);
    flushAll();
    chk("R4 older lane line first", 64'(logLine[base]), 64'h400);
    chk("R4 younger lane line second", 64'(logLine[base+1]), 64'h500);
    chk("R4 younger lane mask", logMask[base+1], 64'h2);
  endtask

  task automatic testFullOrder();
    int base;
    base = logCnt;
    idle(); setLane(0, 34'h600, 0, 64'h11, 0); tick();
    idle(); setLane(0, 34'h700, 0, 64'h22, 0); tick();
    idle();
    setLane(0, 34'h800, 0, 64'h33, 0);
    setLane(1, 34'h600, 1, 64'h44, 0);
    tick();
    chk("R4 lane1 held behind blocked lane0", 64'(takeSeen), 64'd0);
    chk("R5 oldest leaves on demand", 64'(logLine[base]), 64'h600);
    chk("R5 drained mask", logMask[base], 64'h1);
    tick();
    chk("R5 lane0 taken next cycle only lane0", 64'(takeSeen), 64'd1);
    flushAll();
    chk("R7 oldest first in flush", 64'(logLine[base+1]), 64'h700);
    chk("R7 then newer line", 64'(logLine[base+2]), 64'h800);
  endtask

  task automatic testBusy();
    int base;
    base = logCnt;
    idle(); setLane(0, 34'h900, 0, 64'h01, 0); tick();
    idle(); setLane(0, 34'hA00, 0, 64'h02, 0); tick();
    portBusy = 1'b1;
    idle(); setLane(0, 34'hB00, 0, 64'h03, 0); tick();
    chk("R5 fresh line refused when full", 64'(takeSeen), 64'd0);
    chk("R6 no write while busy", 64'(wrSeen), 64'd0);
    idle(); setLane(0, 34'hA00, 5, 64'h04, 0); tick();
    chk("R6 merge taken while busy", 64'(takeSeen), 64'd1);
    portBusy = 1'b0;
    idle(); setLane(0, 34'hB00, 0, 64'h03, 0); tick();
    chk("R5 not taken while evicting", 64'(takeSeen), 64'd0);
    chk("R5 evicts oldest after busy", 64'(logLine[base]), 64'h900);
    tick();
    chk("R5 taken after eviction", 64'(takeSeen), 64'd1);
    flushAll();
    chk("R6 merged during busy kept", logMask[base+1], 64'h21);
    chk("R6 merged byte value", 64'(logData[base+1][47:40]), 64'h04);
  endtask

  task automatic testFlushBusy();
    int base;
    base = logCnt;
    idle(); setLane(0, 34'hC00, 2, 64'h77, 0); tick();
    flushReq = 1'b1;
    portBusy = 1'b1;
    idle(); setLane(0, 34'hC00, 3, 64'h88, 0); tick();
    chk("R7 store held off during flush", 64'(takeSeen), 64'd0);
    chk("R6 flush waits for port", 64'(wrSeen), 64'd0);
    portBusy = 1'b0;
    tick();
    chk("R7 flush write issued", 64'(logCnt - base), 64'd1);
    chk("R7 flushed mask", logMask[base], 64'h4);
    flushReq = 1'b0;
    idle();
    chk("R7 empty after drain", 64'(stageEmpty), 64'd1);
  endtask

  initial begin
    int cyc;
    cyc = 0;
    while (cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rstN     = 1'b0;
    flushReq = 1'b0;
    portBusy = 1'b0;
    idle();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testSameLine();
    testSplit();
    testTwoLanes();
    testFullOrder();
    testBusy();
    testFlushBusy();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule